// File: doc/BRIEF.md
# Programmable 32-Source Interrupt Controller

This block gathers 32 external interrupt request lines and presents them to a processor as two interrupt outputs. One is a normal interrupt and one is a critical interrupt. Each line passes through a two-flop synchroniser. Software then chooses, per source, whether the line is active high or active low, and whether it is level or edge sensitive. Detected requests latch into a sticky status register, which software clears by writing 1s. An enable register gates the status. A routing register steers each enabled source to either the normal output or the critical output.

A register bus with a write strobe and a read strobe gives software access to the configuration and status registers. It also exposes a read-only masked status view and a read-only priority index. The priority index names the lowest-numbered pending enabled source, or flags that nothing is pending. Source n always occupies register bit 31−n, so source 0, which has the highest priority, is the most significant bit.

Top module: `irq_ctrl`

## Requirements
- R1: After reset the registers read: status 0x0000_0000, enable 0x0000_0000, routing 0xFFFF_FFFF, polarity 0xFFFF_FFFF, trigger 0x0000_0000, masked 0, priority 0x8000_0000. Both outputs are low.
- R2: Each source passes two synchronising flops. A change on `src_i[n]` can reach status bit 31−n at the third rising edge after it is applied, and not earlier.
- R3: Polarity register (offset 0x0C) bit 31−n equal to 1 makes source n active high. A value of 0 makes it active low.
- R4: Trigger bit 31−n equal to 0 selects level mode. In level mode the status bit is set on every edge while the synchronised input is active, so a clear while the input is active does not stick.
- R5: Trigger register (offset 0x10) bit equal to 1 selects edge mode. In edge mode the status bit is set only on an inactive-to-active transition, and stays clear after a clear while the input stays active.
- R6: Status (offset 0x00) is sticky. Writing a 1 to a bit clears it, and writing a 0 leaves it unchanged. If a new request and a clear hit the same bit in the same cycle, the request wins.
- R7: Enable (offset 0x04) is read/write. Masked status (offset 0x14) reads status AND enable.
- R8: Routing (offset 0x08) bit equal to 1 sends the source to `irq_norm_o`, and a 0 sends it to `irq_crit_o`. Each output is the OR of the masked bits routed to it, registered one cycle later.
- R9: The priority register (offset 0x18) reads bit 31 = 1 and bits 4:0 = 0 when masked status is zero. Otherwise it reads bit 31 = 0 and bits 4:0 = the lowest source number whose masked bit is set. All other bits read 0.
- R10: Writes to offsets 0x14, 0x18 and unmapped offsets change no register. Reads of unmapped offsets, or any read with `bus_rd` low, return 0. `bus_rdata` is combinational from the current register state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | 32 | Raw interrupt lines, bit n is source n |
| bus_addr | input | AW (8) | Byte offset of the register |
| bus_wr | input | 1 | Write strobe, one write per cycle high |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data |
| irq_norm_o | output | 1 | Normal interrupt output |
| irq_crit_o | output | 1 | Critical interrupt output |

## Verification
A write-1-to-clear on the status register can land in the same cycle as a fresh detection of the same source. Level mode with the input held active, and a random mix of source toggles and status writes, both provoke this. The bench judges it against a cycle-level reference model in which the new request survives the clear. A second collision is a polarity or trigger rewrite coinciding with an input change. The same model judges it, because it computes activity from the register values in force at each edge.

// File: rtl/irq_ctrl.sv
module irq_ctrl #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [31:0]   src_i,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [31:0]   bus_wdata,
  input  logic          bus_rd,
  output logic [31:0]   bus_rdata,
  output logic          irq_norm_o,
  output logic          irq_crit_o
);
  localparam logic [AW-1:0] OFS_STAT = AW'(8'h00);
  localparam logic [AW-1:0] OFS_EN   = AW'(8'h04);
  localparam logic [AW-1:0] OFS_RTE  = AW'(8'h08);
  localparam logic [AW-1:0] OFS_POL  = AW'(8'h0C);
  localparam logic [AW-1:0] OFS_TRG  = AW'(8'h10);
  localparam logic [AW-1:0] OFS_MSK  = AW'(8'h14);
  localparam logic [AW-1:0] OFS_PRI  = AW'(8'h18);

  logic [31:0] src_rev, sync1, sync2, act, act_q, set_v;
  logic [31:0] status, enable, route, pol, trig, masked;
  logic [4:0]  prio_idx;
  logic        prio_none;

  always_comb
    for (int i = 0; i < 32; i++) src_rev[31-i] = src_i[i];

  assign act    = ~(sync2 ^ pol);
  assign set_v  = act & ~(trig & act_q);
  assign masked = status & enable;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1      <= '0;
      sync2      <= '0;
      act_q      <= '0;
      status     <= '0;
      enable     <= '0;
      route      <= '1;
      pol        <= '1;
      trig       <= '0;
      irq_norm_o <= 1'b0;
      irq_crit_o <= 1'b0;
    end else begin
      sync1      <= src_rev;
      sync2      <= sync1;
      act_q      <= act;
      status     <= (status & ~((bus_wr && bus_addr == OFS_STAT) ? bus_wdata : 32'h0)) | set_v;
      irq_norm_o <= |(masked & route);
      irq_crit_o <= |(masked & ~route);
      if (bus_wr) begin
        if (bus_addr == OFS_EN)  enable <= bus_wdata;
        if (bus_addr == OFS_RTE) route  <= bus_wdata;
        if (bus_addr == OFS_POL) pol    <= bus_wdata;
        if (bus_addr == OFS_TRG) trig   <= bus_wdata;
      end
    end
  end

  always_comb begin
    prio_idx  = '0;
    prio_none = 1'b1;
    for (int b = 0; b < 32; b++)
      if (masked[b]) begin
        prio_idx  = 5'(31 - b);
        prio_none = 1'b0;
      end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd)
      case (bus_addr)
        OFS_STAT: bus_rdata = status;
        OFS_EN:   bus_rdata = enable;
        OFS_RTE:  bus_rdata = route;
        OFS_POL:  bus_rdata = pol;
        OFS_TRG:  bus_rdata = trig;
        OFS_MSK:  bus_rdata = masked;
        OFS_PRI:  bus_rdata = {prio_none, 26'b0, prio_idx};
        default:  bus_rdata = '0;
      endcase
  end
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr,
  input logic [31:0]   bus_wdata,
  input logic [31:0]   set_v,
  input logic [31:0]   status,
  input logic [31:0]   enable,
  input logic [31:0]   route,
  input logic [31:0]   masked,
  input logic [4:0]    prio_idx,
  input logic          prio_none,
  input logic          irq_norm_o,
  input logic          irq_crit_o
);
  AST_NORM_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq_norm_o == $past(|(masked & route)));  // R8
  AST_CRIT_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq_crit_o == $past(|(masked & ~route)));  // R8
  AST_REQ_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (status & $past(set_v)) == $past(set_v));  // R6
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'(8'h00) && set_v == 32'h0) |=> (status & $past(bus_wdata)) == 32'h0);  // R6
  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == AW'(8'h04)) |=> $stable(enable));  // R10
  AST_PRIO_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    !prio_none |-> masked[31 - prio_idx]);  // R9
endmodule

bind irq_ctrl irq_ctrl_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .set_v(set_v), .status(status), .enable(enable),
  .route(route), .masked(masked), .prio_idx(prio_idx), .prio_none(prio_none),
  .irq_norm_o(irq_norm_o), .irq_crit_o(irq_crit_o)
);

// File: tb/test_irq_ctrl.sv
`timescale 1ns/1ps
module test_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] b_src = '0;
  logic [7:0]  b_addr = '0;
  logic        b_wr = 1'b0;
  logic [31:0] b_wdata = '0;
  logic        b_rd = 1'b1;
  logic [31:0] bus_rdata;
  logic        irq_norm_o, irq_crit_o;

  int n_cmp = 0, n_bad = 0;

  logic [31:0] m_s1, m_s2, m_actq, m_stat, m_en, m_rte, m_pol, m_trg;
  logic        m_norm, m_crit;

  always #10 clk = ~clk;

  irq_ctrl i_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .src_i(b_src), .bus_addr(b_addr), .bus_wr(b_wr),
    .bus_wdata(b_wdata), .bus_rd(b_rd), .bus_rdata(bus_rdata),
    .irq_norm_o(irq_norm_o), .irq_crit_o(irq_crit_o)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rev(input logic [31:0] v);
    for (int i = 0; i < 32; i++) rev[31-i] = v[i];
  endfunction

  function automatic logic [31:0] m_read(input logic [7:0] a);
    logic [31:0] mk;
    mk = m_stat & m_en;
    case (a)
      8'h00: return m_stat;
      8'h04: return m_en;
      8'h08: return m_rte;
      8'h0C: return m_pol;
      8'h10: return m_trg;
      8'h14: return mk;
      8'h18: begin
        for (int n = 0; n < 32; n++) if (mk[31-n]) return 32'(n);
        return 32'h8000_0000;
      end
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(input logic [7:0] a);
    case (a)
      8'h00: return "R6";
      8'h04: return "R7";
      8'h08: return "R8";
      8'h0C: return "R3";
      8'h10: return "R5";
      8'h14: return "R7";
      8'h18: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic m_reset();
    m_s1 = '0; m_s2 = '0; m_actq = '0; m_stat = '0; m_en = '0;
    m_rte = '1; m_pol = '1; m_trg = '0; m_norm = 0; m_crit = 0;
  endtask

  task automatic m_edge();
    logic [31:0] act, set, clr, mk;
    act = ~(m_s2 ^ m_pol);
    set = (m_trg & act & ~m_actq) | (~m_trg & act);
    clr = (b_wr && b_addr == 8'h00) ? b_wdata : 32'h0;
    mk  = m_stat & m_en;
    m_norm = |(mk & m_rte);
    m_crit = |(mk & ~m_rte);
    m_stat = (m_stat & ~clr) | set;
    m_actq = act;
    m_s2 = m_s1;
    m_s1 = rev(b_src);
    if (b_wr) case (b_addr)
      8'h04: m_en  = b_wdata;
      8'h08: m_rte = b_wdata;
      8'h0C: m_pol = b_wdata;
      8'h10: m_trg = b_wdata;
      default: ;
    endcase
  endtask

  task automatic cyc();
    #1;
    chk(bus_rdata, b_rd ? m_read(b_addr) : 32'h0, tag_of(b_addr));
    chk({31'b0, irq_norm_o}, {31'b0, m_norm}, "R8 norm");
    chk({31'b0, irq_crit_o}, {31'b0, m_crit}, "R8 crit");
    @(posedge clk);
    m_edge();
    @(negedge clk);
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    b_addr = a; b_wdata = d; b_wr = 1'b1;
    cyc();
    b_wr = 1'b0;
  endtask

  task automatic expect_reg(input logic [7:0] a, input logic [31:0] e, input string tag);
    b_addr = a;
    #1;
    chk(bus_rdata, e, tag);
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values
    expect_reg(8'h00, 32'h0, "R1 status");
    expect_reg(8'h04, 32'h0, "R1 enable");
    expect_reg(8'h08, 32'hFFFF_FFFF, "R1 route");
    expect_reg(8'h0C, 32'hFFFF_FFFF, "R1 pol");
    expect_reg(8'h10, 32'h0, "R1 trig");
    expect_reg(8'h14, 32'h0, "R1 masked");
    expect_reg(8'h18, 32'h8000_0000, "R1 prio");
    chk({30'b0, irq_norm_o, irq_crit_o}, 32'h0, "R1 outputs");
    b_rd = 1'b0;
    expect_reg(8'h08, 32'h0, "R10 rd low");
    b_rd = 1'b1;

    wr_reg(8'h04, 32'hFFFF_FFFF);
    // R2: source 5 -> bit 26, third edge
    b_src = 32'h20;
    cyc(); expect_reg(8'h00, 32'h0, "R2 edge1");
    cyc(); expect_reg(8'h00, 32'h0, "R2 edge2");
    cyc(); expect_reg(8'h00, 32'h0400_0000, "R2 edge3");
    expect_reg(8'h18, 32'h5, "R9 idx");
    // R4: clear while active level does not stick
    wr_reg(8'h00, 32'h0400_0000);
    expect_reg(8'h00, 32'h0400_0000, "R4 level reassert");
    // R3: active low on source 5
    wr_reg(8'h0C, ~32'h0400_0000);
    wr_reg(8'h00, 32'h0400_0000);
    expect_reg(8'h00, 32'h0, "R3 high inactive");
    b_src = 32'h0;
    cyc(); cyc(); expect_reg(8'h00, 32'h0, "R3 not yet");
    cyc(); expect_reg(8'h00, 32'h0400_0000, "R3 low active");
    // R5: edge mode
    wr_reg(8'h10, 32'h0400_0000);
    wr_reg(8'h0C, 32'hFFFF_FFFF);
    wr_reg(8'h00, 32'h0400_0000);
    expect_reg(8'h00, 32'h0, "R5 cleared");
    b_src = 32'h20;
    cyc(); cyc(); cyc(); expect_reg(8'h00, 32'h0400_0000, "R5 edge sets");
    wr_reg(8'h00, 32'h0400_0000);
    cyc(); cyc(); cyc(); expect_reg(8'h00, 32'h0, "R5 no reassert");
    // R10: read-only offsets ignore writes
    wr_reg(8'h14, 32'h0);
    wr_reg(8'h18, 32'hFFFF_FFFF);
    wr_reg(8'h1C, 32'hFFFF_FFFF);
    expect_reg(8'h04, 32'hFFFF_FFFF, "R10 enable kept");
    expect_reg(8'h1C, 32'h0, "R10 unmapped");

    for (int k = 0; k < 4000; k++) begin
      logic [7:0] a;
      a = 8'(($urandom % 8) * 4);
      b_src = b_src ^ ($urandom & $urandom & $urandom);
      b_addr = a;
      if ($urandom % 4 == 0) begin
        b_wr = 1'b1;
        b_wdata = (a == 8'h00) ? ($urandom & $urandom) : $urandom;
      end else b_wr = 1'b0;
      cyc();
    end
    b_wr = 1'b0;

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule